// File: doc/BRIEF.md
# Configuration Bitstream Header Parser

This block reads a configuration file as a stream of bytes over a valid/ready handshake and finds one requested header section in it. After a start pulse it first checks that the stream opens with a fixed 13-byte preamble. It then walks the tagged sections that follow. Each section is one ASCII tag byte, then a big-endian length, then that many content bytes. A section with a different tag has its content read and dropped.

When the requested tag is found, the parser reports the section length and stops taking bytes. The next byte on the stream is then the first content byte, which a downstream consumer can take. The parser never rewinds. Three conditions end a search without a match: an unknown tag, an implausible length, or a spent byte budget. The result flags stay valid until the next start pulse.

Top module: `bitstream_hdr_parser`

## Requirements
- R1: After start, the first 13 accepted bytes must equal 00 09 0F F0 0F F0 0F F0 0F F0 00 00 01. The first byte that differs sets error and done, clears found, and no section search takes place.
- R2: Tags 0x61..0x64 ('a'..'d') carry a 2-byte length and tag 0x65 ('e') carries a 4-byte length. In both cases the most significant byte comes first.
- R3: When the tag of a section equals the tag sampled at start, the parser sets found and done. The length output shows the section length, and byte_ready_o is low from the cycle after the last length byte, so no content byte is taken.
- R4: A section whose tag differs from the request has exactly its length in content bytes consumed and dropped. A zero length goes straight to the next tag.
- R5: A tag byte outside 0x61..0x65 ends the search with done set and both found and error clear.
- R6: On tags 'a'..'d', a length above 255 sets error and done. Tag 'e' has no such limit.
- R7: After the preamble, at most BUDGET (default 100) bytes are consumed, counting tag, length and skipped content bytes. When the budget is spent the search ends with done set and found and error clear. A match or a length error completed by the final budget byte takes precedence over this.
- R8: byte_ready_o is low while the parser is idle or done. found, error, done and the length output hold until the next start. A start pulse in any state clears them and restarts preamble checking.
- R9: After reset, byte_ready_o, found, error, done and the length output are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse; samples tag_i and restarts parsing |
| tag_i | input | 8 | Requested section tag (ASCII) |
| byte_data_i | input | 8 | Stream byte |
| byte_valid_i | input | 1 | Stream byte is valid |
| byte_ready_o | output | 1 | Parser takes the byte this cycle |
| found_o | output | 1 | Requested section found |
| error_o | output | 1 | Preamble mismatch or oversized short length |
| done_o | output | 1 | Search finished |
| sect_len_o | output | 32 | Length of the found section, zero otherwise |

## Verification
The assertions check the following on every cycle:
- byte_ready_o is low once the parser is done.
- found and error are never set together, and found implies done.
- The result flags and the length hold until a start pulse.
- The total bytes accepted since start never exceed the preamble plus the budget.

Only the bench scenarios can show the rest:
- the exact byte order of the preamble,
- the big-endian assembly of 2- and 4-byte lengths,
- correct skipping of content,
- the length error applying to short tags but not to 'e',
- the precedence of a match on the very last budget byte.

// File: rtl/bhp_pkg.sv
package bhp_pkg;

    localparam int PRE_LEN = 13;
    localparam int LEN_W   = 32;

    localparam logic [7:0] TAG_LO   = 8'h61;
    localparam logic [7:0] TAG_WIDE = 8'h65;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_TAG,
        ST_LEN,
        ST_SKIP,
        ST_DONE
    } parse_st_e;

    typedef struct packed {
        logic found;
        logic error;
        logic done;
    } result_t;

    function automatic logic [7:0] pre_byte(input logic [3:0] idx);
        case (idx)
            4'd0, 4'd10, 4'd11:     return 8'h00;
            4'd1:                   return 8'h09;
            4'd2, 4'd4, 4'd6, 4'd8: return 8'h0F;
            4'd3, 4'd5, 4'd7, 4'd9: return 8'hF0;
            default:                return 8'h01;
        endcase
    endfunction

    function automatic logic tag_known(input logic [7:0] t);
        return (t >= TAG_LO) && (t <= TAG_WIDE);
    endfunction

endpackage

// File: rtl/bhp_budget.sv
module bhp_budget #(
    parameter int BUDGET = 100,
    localparam int CW = $clog2(BUDGET + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic inc,
    output logic last_o
);
    logic [CW-1:0] used_q;

    always_ff @(posedge clk) begin
        if (rst || clr)
            used_q <= '0;
        else if (inc)
            used_q <= used_q + 1'b1;
    end

    // the byte being taken now is the final one permitted
    assign last_o = (used_q == CW'(BUDGET - 1));
endmodule

// File: rtl/bhp_len_acc.sv
module bhp_len_acc #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         shift,
    input  logic [7:0]   din,
    output logic [W-1:0] next_o
);
    logic [W-1:0] acc_q;

    assign next_o = {acc_q[W-9:0], din};

    always_ff @(posedge clk) begin
        if (rst || clr)
            acc_q <= '0;
        else if (shift)
            acc_q <= next_o;
    end
endmodule

// File: rtl/bitstream_hdr_parser.sv
module bitstream_hdr_parser
    import bhp_pkg::*;
#(
    parameter int BUDGET = 100
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start_i,
    input  logic [7:0]  tag_i,
    input  logic [7:0]  byte_data_i,
    input  logic        byte_valid_i,
    output logic        byte_ready_o,
    output logic        found_o,
    output logic        error_o,
    output logic        done_o,
    output logic [31:0] sect_len_o
);
    parse_st_e         st_q;
    logic [3:0]        pre_idx_q;
    logic [7:0]        req_tag_q;
    logic [7:0]        cur_tag_q;
    logic [2:0]        len_left_q;
    logic [LEN_W-1:0]  skip_left_q;
    logic [LEN_W-1:0]  len_q;
    result_t           res_q;

    logic              accept;
    logic              in_search;
    logic              budget_last;
    logic [LEN_W-1:0]  len_next;

    assign byte_ready_o = (st_q == ST_PRE) || (st_q == ST_TAG) ||
                          (st_q == ST_LEN) || (st_q == ST_SKIP);
    assign accept    = byte_valid_i && byte_ready_o;
    assign in_search = (st_q == ST_TAG) || (st_q == ST_LEN) || (st_q == ST_SKIP);

    bhp_budget #(.BUDGET(BUDGET)) u_budget (
        .clk    (clk),
        .rst    (rst),
        .clr    (start_i),
        .inc    (accept && in_search),
        .last_o (budget_last)
    );

    bhp_len_acc #(.W(LEN_W)) u_len (
        .clk    (clk),
        .rst    (rst),
        .clr    (start_i || (accept && st_q == ST_TAG)),
        .shift  (accept && st_q == ST_LEN),
        .din    (byte_data_i),
        .next_o (len_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q        <= ST_IDLE;
            pre_idx_q   <= '0;
            req_tag_q   <= '0;
            cur_tag_q   <= '0;
            len_left_q  <= '0;
            skip_left_q <= '0;
            len_q       <= '0;
            res_q       <= '0;
        end else if (start_i) begin
            st_q      <= ST_PRE;
            pre_idx_q <= '0;
            req_tag_q <= tag_i;
            len_q     <= '0;
            res_q     <= '0;
        end else if (accept) begin
            unique case (st_q)
                ST_PRE: begin
                    if (byte_data_i != pre_byte(pre_idx_q)) begin
                        st_q       <= ST_DONE;
                        res_q.error <= 1'b1;
                        res_q.done  <= 1'b1;
                    end else if (pre_idx_q == 4'(PRE_LEN - 1)) begin
                        st_q <= ST_TAG;
                    end else begin
                        pre_idx_q <= pre_idx_q + 1'b1;
                    end
                end
                ST_TAG: begin
                    if (!tag_known(byte_data_i) || budget_last) begin
                        st_q       <= ST_DONE;
                        res_q.done <= 1'b1;
                    end else begin
                        cur_tag_q  <= byte_data_i;
                        len_left_q <= (byte_data_i == TAG_WIDE) ? 3'd4 : 3'd2;
                        st_q       <= ST_LEN;
                    end
                end
                ST_LEN: begin
                    if (len_left_q == 3'd1) begin
                        if (cur_tag_q != TAG_WIDE && len_next > 255) begin
                            st_q        <= ST_DONE;
                            res_q.error <= 1'b1;
                            res_q.done  <= 1'b1;
                        end else if (cur_tag_q == req_tag_q) begin
                            st_q        <= ST_DONE;
                            res_q.found <= 1'b1;
                            res_q.done  <= 1'b1;
                            len_q       <= len_next;
                        end else if (budget_last) begin
                            st_q       <= ST_DONE;
                            res_q.done <= 1'b1;
                        end else if (len_next == '0) begin
                            st_q <= ST_TAG;
                        end else begin
                            skip_left_q <= len_next;
                            st_q        <= ST_SKIP;
                        end
                    end else if (budget_last) begin
                        st_q       <= ST_DONE;
                        res_q.done <= 1'b1;
                    end else begin
                        len_left_q <= len_left_q - 1'b1;
                    end
                end
                ST_SKIP: begin
                    if (budget_last) begin
                        st_q       <= ST_DONE;
                        res_q.done <= 1'b1;
                    end else if (skip_left_q == LEN_W'(1)) begin
                        st_q <= ST_TAG;
                    end else begin
                        skip_left_q <= skip_left_q - 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    assign found_o    = res_q.found;
    assign error_o    = res_q.error;
    assign done_o     = res_q.done;
    assign sect_len_o = len_q;
endmodule

// File: rtl/bhp_checker.sv
module bhp_checker #(
    parameter int BUDGET = 100
) (
    input logic        clk,
    input logic        rst,
    input logic        start_i,
    input logic        byte_valid_i,
    input logic        byte_ready_o,
    input logic        found_o,
    input logic        error_o,
    input logic        done_o,
    input logic [31:0] sect_len_o
);
    localparam int MAXB = bhp_pkg::PRE_LEN + BUDGET;
    localparam int CW   = $clog2(MAXB + 2);

    logic [CW-1:0] taken_q;

    always_ff @(posedge clk) begin
        if (rst || start_i)
            taken_q <= '0;
        else if (byte_valid_i && byte_ready_o && taken_q != '1)
            taken_q <= taken_q + 1'b1;
    end

    // R8
    ready_low_done_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !byte_ready_o);

    // R3
    found_means_done_chk: assert property (@(posedge clk) disable iff (rst)
        found_o |-> done_o);

    // R6
    found_error_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(found_o && error_o));

    // R8
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (done_o && !start_i) |=> (done_o && $stable(found_o) && $stable(error_o)
                                  && $stable(sect_len_o)));

    // R7
    budget_bound_chk: assert property (@(posedge clk) disable iff (rst)
        taken_q <= CW'(MAXB));
endmodule

bind bitstream_hdr_parser bhp_checker #(.BUDGET(BUDGET)) u_bhp_chk (
    .clk          (clk),
    .rst          (rst),
    .start_i      (start_i),
    .byte_valid_i (byte_valid_i),
    .byte_ready_o (byte_ready_o),
    .found_o      (found_o),
    .error_o      (error_o),
    .done_o       (done_o),
    .sect_len_o   (sect_len_o)
);

// File: tb/bitstream_hdr_parser_test.sv
module bitstream_hdr_parser_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [7:0]  tag_i = 8'h00;
    logic [7:0]  byte_data_i = 8'h00;
    logic        byte_valid_i = 1'b0;
    logic        byte_ready_o;
    logic        found_o, error_o, done_o;
    logic [31:0] sect_len_o;

    int n_checks = 0;
    int n_fails  = 0;
    int n_taken  = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    bitstream_hdr_parser uut (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] b);
        @(negedge clk);
        if (!byte_ready_o) begin
            byte_valid_i = 1'b0;
            return;
        end
        byte_data_i  = b;
        byte_valid_i = 1'b1;
        n_taken++;
        @(posedge clk);
    endtask

    task automatic idle_bus;
        @(negedge clk);
        byte_valid_i = 1'b0;
    endtask

    task automatic begin_run(input logic [7:0] t);
        @(negedge clk);
        byte_valid_i = 1'b0;
        start_i = 1'b1;
        tag_i   = t;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic send_pre;
        logic [7:0] p [13] = '{8'h00, 8'h09, 8'h0F, 8'hF0, 8'h0F, 8'hF0, 8'h0F,
                               8'hF0, 8'h0F, 8'hF0, 8'h00, 8'h00, 8'h01};
        for (int i = 0; i < 13; i++) push(p[i]);
        n_taken = 0;
    endtask

    task automatic expect_res(input string req, input logic f, input logic e, input logic [31:0] len);
        idle_bus();
        check({req, " done"}, 32'(done_o), 32'd1);
        check({req, " found"}, 32'(found_o), 32'(f));
        check({req, " error"}, 32'(error_o), 32'(e));
        check({req, " length"}, sect_len_o, len);
        check({req, " ready low"}, 32'(byte_ready_o), 32'd0);
    endtask

    // R9
    task automatic t_reset;
        check("R9 ready", 32'(byte_ready_o), 0);
        check("R9 flags", {29'd0, found_o, error_o, done_o}, 0);
        check("R9 length", sect_len_o, 0);
    endtask

    // R2 R4 R3: skip a, zero-length c, b, then find wide tag e
    task automatic t_find_wide;
        begin_run(8'h65);
        check("R8 ready after start", 32'(byte_ready_o), 1);
        send_pre();
        push(8'h61); push(8'h00); push(8'h02); push(8'h41); push(8'h42);
        push(8'h63); push(8'h00); push(8'h00);
        push(8'h62); push(8'h00); push(8'h01); push(8'h43);
        push(8'h65); push(8'h00); push(8'h01); push(8'h23); push(8'h45);
        expect_res("R2 R3 R4 wide", 1'b1, 1'b0, 32'h0001_2345);
        push(8'hAA);
        check("R3 no content taken", 32'(n_taken), 17);
    endtask

    // R2 R3: short tag matched first
    task automatic t_find_short;
        begin_run(8'h62);
        send_pre();
        push(8'h62); push(8'h00); push(8'hF7);
        expect_res("R2 R3 short", 1'b1, 1'b0, 32'h0000_00F7);
    endtask

    // R1: mismatch at byte index 5
    task automatic t_bad_pre;
        begin_run(8'h61);
        push(8'h00); push(8'h09); push(8'h0F); push(8'hF0); push(8'h0F);
        n_taken = 0;
        push(8'h0F);
        expect_res("R1 preamble", 1'b0, 1'b1, 32'd0);
        push(8'h61);
        check("R1 no search", 32'(n_taken), 1);
    endtask

    // R5
    task automatic t_bad_tag;
        begin_run(8'h61);
        send_pre();
        push(8'h62); push(8'h00); push(8'h00);
        push(8'h7A);
        expect_res("R5 unknown tag", 1'b0, 1'b0, 32'd0);
    endtask

    // R6: 0x0100 on tag c
    task automatic t_long_short;
        begin_run(8'h61);
        send_pre();
        push(8'h63); push(8'h01); push(8'h00);
        expect_res("R6 length limit", 1'b0, 1'b1, 32'd0);
    endtask

    // R6 R7: e exempt from limit, skip runs into budget
    task automatic t_budget_wide;
        begin_run(8'h61);
        send_pre();
        push(8'h65); push(8'h00); push(8'h00); push(8'h02); push(8'h00);
        for (int i = 0; i < 200; i++) push(8'h55);
        expect_res("R6 R7 budget", 1'b0, 1'b0, 32'd0);
        check("R7 bytes taken", 32'(n_taken), 100);
    endtask

    // R7: match completed by the final budget byte
    task automatic t_budget_edge(input logic [7:0] last_tag, input logic exp_f);
        begin_run(8'h64);
        send_pre();
        push(8'h61); push(8'h00); push(8'd94);
        for (int i = 0; i < 94; i++) push(8'h11);
        push(last_tag); push(8'h00); push(8'h00);
        expect_res(exp_f ? "R7 edge match" : "R7 edge miss", exp_f, 1'b0, 32'd0);
        check("R7 edge count", 32'(n_taken), 100);
    endtask

    // R8: restart in the middle of a skip
    task automatic t_restart;
        begin_run(8'h64);
        send_pre();
        push(8'h61); push(8'h00); push(8'h10); push(8'h01);
        begin_run(8'h61);
        check("R8 restart clears done", 32'(done_o), 0);
        send_pre();
        push(8'h61); push(8'h00); push(8'h33);
        expect_res("R8 restart", 1'b1, 1'b0, 32'h33);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R8 hold found", 32'(found_o), 1);
        check("R8 hold length", sect_len_o, 32'h33);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_find_wide();
        t_find_short();
        t_bad_pre();
        t_bad_tag();
        t_long_short();
        t_budget_wide();
        t_budget_edge(8'h64, 1'b1);
        t_budget_edge(8'h62, 1'b0);
        t_restart();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule